// File: doc/BRIEF.md
# Byte-FIFO Host Register Front End for a Programmed-I/O Card Controller

This block is the memory-mapped slave side of a card host controller that runs without DMA. Software reaches the card engines only through four byte queues. It writes a command byte to one queue and reads response bytes from a second queue. It writes outgoing block data to a third queue and reads incoming block data from a fourth. A read-only status word reports when each host-write queue is full and when each host-read queue is empty. There is no busy bit, so software decides that a command has finished by polling these flags.

The card-side engines see each queue as a simple strobe port. A transmit queue shows its oldest byte together with an empty flag, and a pop strobe removes that byte. A receive queue takes a push strobe with a data byte and reports a full flag. All queues share one clock and clear on a synchronous reset.

Each queue tracks its occupancy with a three-state machine. The states are `FILL_EMPTY`, `FILL_PART` and `FILL_FULL`. An accepted push or pop moves the machine. It goes to `FILL_EMPTY` when the next count is zero, to `FILL_FULL` when the next count equals the depth, and to `FILL_PART` for any other count. A push and a pop in the same cycle leave the count and the state unchanged. The full and empty flags are decoded from the state.

Top module: `sdh_fifo_regif`

## Requirements
- R1: A host write to byte offset 0x00 appends `bus_wdata` to the command transmit queue. The card side sees the bytes at `ctx_head` in write order, and a `ctx_pop` strobe removes the head byte.
- R2: A host read of offset 0x04 removes the oldest byte of the command receive queue. That byte appears on `bus_rdata` one clock after the read strobe. `bus_rdata` then holds its value until the next read strobe.
- R3: A host write to offset 0x08 appends `bus_wdata` to the data transmit queue. The card side sees these bytes in order at `dtx_head` and removes them with `dtx_pop`.
- R4: A host read of offset 0x0C removes the oldest byte of the data receive queue and returns it on `bus_rdata` one clock later. The bytes come out in the order that `drx_push` put them in.
- R5: A read of offset 0x10 returns the status byte. Bit 0 is set when the command transmit queue is full. Bit 1 is set when the command receive queue is empty. Bit 2 is set when the data transmit queue is full. Bit 3 is set when the data receive queue is empty. Bits 7:4 are zero.
- R6: Every queue holds 16 bytes. A push into a full queue is discarded, from either the host or the card side, and the stored contents and their order stay as they were.
- R7: A read or pop of an empty queue has no effect on it. A host read of an empty receive queue returns 0x00, and the head output of an empty transmit queue is 0x00.
- R8: Writes to offsets 0x04, 0x0C and 0x10 change nothing. A read of the write-only offset 0x00 returns 0x00 and does not disturb any queue.
- R9: A synchronous reset empties all four queues. After reset the status byte reads 0x0A and `ctx_empty`/`dtx_empty` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 5 | Host byte address |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered host read data |
| ctx_pop | input | 1 | Card takes a command byte |
| ctx_head | output | 8 | Oldest command transmit byte |
| ctx_empty | output | 1 | Command transmit queue empty |
| crx_push | input | 1 | Card stores a response byte |
| crx_data | input | 8 | Response byte |
| crx_full | output | 1 | Command receive queue full |
| dtx_pop | input | 1 | Card takes a data byte |
| dtx_head | output | 8 | Oldest data transmit byte |
| dtx_empty | output | 1 | Data transmit queue empty |
| drx_push | input | 1 | Card stores a data byte |
| drx_data | input | 8 | Incoming data byte |
| drx_full | output | 1 | Data receive queue full |

## Verification
The bench uses the default queue depth of 16 and byte width of 8. At that depth a queue can be filled to its limit and pushed once more in a few dozen cycles. The full flag, the discarded seventeenth byte and the wrap of both pointers past entry 15 are therefore all exercised, for a host-side queue and for a card-side queue. The five-byte response pattern and a reset with traffic still queued are also covered at these values.

// File: rtl/sdh_regif_pkg.sv
package sdh_regif_pkg;

    localparam int ADDR_W  = 5;
    localparam int BYTE_W  = 8;
    localparam int Q_DEPTH = 16;
    localparam int NUM_Q   = 4;

    // queue index: even = host writes, odd = host reads
    localparam int Q_CMD_TX = 0;
    localparam int Q_CMD_RX = 1;
    localparam int Q_DAT_TX = 2;
    localparam int Q_DAT_RX = 3;

    localparam logic [ADDR_W-1:0] OFS_CMD_TX = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_CMD_RX = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_DAT_TX = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_DAT_RX = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h10;

    typedef enum logic [1:0] {
        FILL_EMPTY = 2'd0,
        FILL_PART  = 2'd1,
        FILL_FULL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/sdh_byte_fifo.sv
module sdh_byte_fifo
    import sdh_regif_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int            AW       = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int            CW       = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [CW-1:0]    cnt, cnt_nxt;
    fill_state_t      state, state_nxt;
    logic             do_push, do_pop;

    assign do_push = push && (state != FILL_FULL);
    assign do_pop  = pop  && (state != FILL_EMPTY);

    // next count and next fill state
    always_comb begin
        cnt_nxt = cnt;
        unique case ({do_push, do_pop})
            2'b10:   cnt_nxt = cnt + 1'b1;
            2'b01:   cnt_nxt = cnt - 1'b1;
            default: cnt_nxt = cnt;
        endcase
        if (cnt_nxt == '0)
            state_nxt = FILL_EMPTY;
        else if (cnt_nxt == CNT_MAX)
            state_nxt = FILL_FULL;
        else
            state_nxt = FILL_PART;
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FILL_EMPTY;
            cnt   <= '0;
            wptr  <= '0;
            rptr  <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            if (do_push)
                wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
            if (do_pop)
                rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wptr] <= wdata;
    end

    // outputs from state
    always_comb begin
        full  = 1'b0;
        empty = 1'b0;
        unique case (state)
            FILL_EMPTY: empty = 1'b1;
            FILL_FULL:  full  = 1'b1;
            default:    ;
        endcase
        head = empty ? '0 : mem[rptr];
    end

    // R6: a discarded push leaves the occupancy alone
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && cnt == $past(cnt)));

    // R7: popping an empty queue keeps it empty with a zero head
    p_empty_pop_r7: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (empty && head == '0));

    // R9: flags never both set
    p_flag_excl_r9: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

endmodule

// File: rtl/sdh_bus_decode.sv
module sdh_bus_decode
    import sdh_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              ctx_full,
    input  logic              crx_empty,
    input  logic              dtx_full,
    input  logic              drx_empty,
    input  logic [BYTE_W-1:0] crx_head,
    input  logic [BYTE_W-1:0] drx_head,
    output logic [1:0]        tx_push,
    output logic [1:0]        rx_pop,
    output logic [BYTE_W-1:0] bus_rdata
);
    logic [BYTE_W-1:0] rd_sel;

    assign tx_push[0] = bus_wr && (bus_addr == OFS_CMD_TX);
    assign tx_push[1] = bus_wr && (bus_addr == OFS_DAT_TX);
    assign rx_pop[0]  = bus_rd && (bus_addr == OFS_CMD_RX);
    assign rx_pop[1]  = bus_rd && (bus_addr == OFS_DAT_RX);

    always_comb begin
        unique case (bus_addr)
            OFS_CMD_RX: rd_sel = crx_head;
            OFS_DAT_RX: rd_sel = drx_head;
            OFS_STAT:   rd_sel = {4'b0000, drx_empty, dtx_full, crx_empty, ctx_full};
            default:    rd_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_sel;
    end

    // R5: upper status bits are zero
    p_stat_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_STAT) |=> (bus_rdata[7:4] == 4'b0000));

    // R7: read of an empty response queue returns zero
    p_rx_empty_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CMD_RX && crx_empty) |=> (bus_rdata == '0));

    // R2: read data holds between reads
    p_rdata_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd) |=> $stable(bus_rdata));

    // R8: a write strobe never pops a receive queue
    p_wr_no_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd) |-> (rx_pop == 2'b00));

endmodule

// File: rtl/sdh_fifo_regif.sv
module sdh_fifo_regif
    import sdh_regif_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [4:0]  bus_addr,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic        ctx_pop,
    output logic [7:0]  ctx_head,
    output logic        ctx_empty,
    input  logic        crx_push,
    input  logic [7:0]  crx_data,
    output logic        crx_full,
    input  logic        dtx_pop,
    output logic [7:0]  dtx_head,
    output logic        dtx_empty,
    input  logic        drx_push,
    input  logic [7:0]  drx_data,
    output logic        drx_full
);
    logic [NUM_Q-1:0]  q_push, q_pop, q_full, q_empty;
    logic [BYTE_W-1:0] q_wdata [NUM_Q];
    logic [BYTE_W-1:0] q_head  [NUM_Q];
    logic [1:0]        tx_push, rx_pop;

    assign q_push = {drx_push, tx_push[1], crx_push, tx_push[0]};
    assign q_pop  = {rx_pop[1], dtx_pop, rx_pop[0], ctx_pop};

    assign q_wdata[Q_CMD_TX] = bus_wdata;
    assign q_wdata[Q_CMD_RX] = crx_data;
    assign q_wdata[Q_DAT_TX] = bus_wdata;
    assign q_wdata[Q_DAT_RX] = drx_data;

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        sdh_byte_fifo #(
            .DEPTH (Q_DEPTH),
            .WIDTH (BYTE_W)
        ) fifo_i (
            .clk   (clk),
            .rst   (rst),
            .push  (q_push[q]),
            .wdata (q_wdata[q]),
            .pop   (q_pop[q]),
            .head  (q_head[q]),
            .full  (q_full[q]),
            .empty (q_empty[q])
        );
    end

    sdh_bus_decode dec_i (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .ctx_full  (q_full[Q_CMD_TX]),
        .crx_empty (q_empty[Q_CMD_RX]),
        .dtx_full  (q_full[Q_DAT_TX]),
        .drx_empty (q_empty[Q_DAT_RX]),
        .crx_head  (q_head[Q_CMD_RX]),
        .drx_head  (q_head[Q_DAT_RX]),
        .tx_push   (tx_push),
        .rx_pop    (rx_pop),
        .bus_rdata (bus_rdata)
    );

    assign ctx_head  = q_head[Q_CMD_TX];
    assign ctx_empty = q_empty[Q_CMD_TX];
    assign dtx_head  = q_head[Q_DAT_TX];
    assign dtx_empty = q_empty[Q_DAT_TX];
    assign crx_full  = q_full[Q_CMD_RX];
    assign drx_full  = q_full[Q_DAT_RX];

endmodule

// File: tb/sdh_fifo_regif_tb_top.sv
module sdh_fifo_regif_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       ctx_pop = 1'b0, dtx_pop = 1'b0, crx_push = 1'b0, drx_push = 1'b0;
    logic [7:0] crx_data = '0, drx_data = '0;
    logic [7:0] ctx_head, dtx_head;
    logic       ctx_empty, dtx_empty, crx_full, drx_full;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sdh_fifo_regif dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctx_pop(ctx_pop), .ctx_head(ctx_head), .ctx_empty(ctx_empty),
        .crx_push(crx_push), .crx_data(crx_data), .crx_full(crx_full),
        .dtx_pop(dtx_pop), .dtx_head(dtx_head), .dtx_empty(dtx_empty),
        .drx_push(drx_push), .drx_data(drx_data), .drx_full(drx_full)
    );

    // vector: {rd, addr[4:0], wdata[7:0], expected[7:0]}
    localparam int NV = 11;
    localparam logic [21:0] VECS [NV] = '{
        {1'b1, 5'h10, 8'h00, 8'h0A},  // R9 status after reset
        {1'b0, 5'h00, 8'hA1, 8'h00},  // R1
        {1'b0, 5'h00, 8'hA2, 8'h00},  // R1
        {1'b0, 5'h08, 8'hB1, 8'h00},  // R3
        {1'b1, 5'h04, 8'h00, 8'h00},  // R7 empty response queue
        {1'b1, 5'h0C, 8'h00, 8'h00},  // R7 empty data queue
        {1'b0, 5'h10, 8'hFF, 8'h00},  // R8 write to status
        {1'b1, 5'h10, 8'h00, 8'h0A},  // R8 status unchanged
        {1'b0, 5'h04, 8'h77, 8'h00},  // R8 write to rx offset
        {1'b1, 5'h00, 8'h00, 8'h00},  // R8 read of write-only offset
        {1'b1, 5'h10, 8'h00, 8'h0A}   // R8 rx queue still empty
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bwr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input logic [4:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic ctx_take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tag, ctx_head, exp);
        ctx_pop = 1'b1;
        @(negedge clk);
        ctx_pop = 1'b0;
    endtask

    task automatic dtx_take(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tag, dtx_head, exp);
        dtx_pop = 1'b1;
        @(negedge clk);
        dtx_pop = 1'b0;
    endtask

    task automatic crx_put(input logic [7:0] d);
        @(negedge clk);
        crx_data = d; crx_push = 1'b1;
        @(negedge clk);
        crx_push = 1'b0;
    endtask

    task automatic drx_put(input logic [7:0] d);
        @(negedge clk);
        drx_data = d; drx_push = 1'b1;
        @(negedge clk);
        drx_push = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R9 ctx_empty after reset", {7'b0, ctx_empty}, 8'h01);
        chk("R9 dtx_empty after reset", {7'b0, dtx_empty}, 8'h01);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i][21])
                brd(VECS[i][20:16], VECS[i][7:0], $sformatf("vector %0d", i));
            else
                bwr(VECS[i][20:16], VECS[i][15:8]);
        end

        // R1 / R3: card side sees bytes in order, then empty
        ctx_take(8'hA1, "R1 first cmd byte");
        ctx_take(8'hA2, "R1 second cmd byte");
        chk("R1 cmd tx drained", {7'b0, ctx_empty}, 8'h01);
        chk("R7 empty cmd tx head zero", ctx_head, 8'h00);
        dtx_take(8'hB1, "R3 data byte");
        chk("R3 data tx drained", {7'b0, dtx_empty}, 8'h01);

        // R7: pop of empty tx queue has no effect
        @(negedge clk); ctx_pop = 1'b1; @(negedge clk); ctx_pop = 1'b0;
        bwr(5'h00, 8'h5C);
        ctx_take(8'h5C, "R7 empty pop left pointers alone");

        // R6: fill command tx, overflow dropped, wrap checked by order
        for (int i = 0; i < 16; i++) bwr(5'h00, 8'h10 + 8'(i));
        brd(5'h10, 8'h0B, "R5 cmd tx full bit");
        bwr(5'h00, 8'hEE);
        for (int i = 0; i < 16; i++) ctx_take(8'h10 + 8'(i), "R6 cmd tx order after drop");
        chk("R6 extra byte discarded", {7'b0, ctx_empty}, 8'h01);

        // R3 / R5: fill data tx
        for (int i = 0; i < 16; i++) bwr(5'h08, 8'h40 + 8'(i));
        brd(5'h10, 8'h0E, "R5 data tx full bit");
        for (int i = 0; i < 16; i++) dtx_take(8'h40 + 8'(i), "R3 data tx order");

        // R2: five-byte response
        for (int i = 0; i < 5; i++) crx_put(8'h31 + 8'(i));
        brd(5'h10, 8'h08, "R5 cmd rx not empty");
        for (int i = 0; i < 5; i++) brd(5'h04, 8'h31 + 8'(i), "R2 response order");
        repeat (3) @(negedge clk);
        chk("R2 read data held", bus_rdata, 8'h35);
        brd(5'h04, 8'h00, "R7 response queue empty read");
        brd(5'h10, 8'h0A, "R5 cmd rx empty again");

        // R4 / R6: card overfills data rx
        for (int i = 0; i < 17; i++) drx_put(8'h80 + 8'(i));
        chk("R6 drx_full", {7'b0, drx_full}, 8'h01);
        brd(5'h10, 8'h02, "R5 data rx not empty");
        for (int i = 0; i < 16; i++) brd(5'h0C, 8'h80 + 8'(i), "R4 data rx order");
        brd(5'h0C, 8'h00, "R7 data rx empty read");

        // R6: card overfills command rx
        for (int i = 0; i < 17; i++) crx_put(8'hC0 + 8'(i));
        chk("R6 crx_full", {7'b0, crx_full}, 8'h01);
        for (int i = 0; i < 16; i++) brd(5'h04, 8'hC0 + 8'(i), "R6 cmd rx order after drop");

        // R9: reset with traffic queued
        bwr(5'h00, 8'h11);
        bwr(5'h08, 8'h22);
        crx_put(8'h33);
        drx_put(8'h44);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R9 ctx_empty after mid reset", {7'b0, ctx_empty}, 8'h01);
        chk("R9 dtx_empty after mid reset", {7'b0, dtx_empty}, 8'h01);
        brd(5'h10, 8'h0A, "R9 status after mid reset");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule